// File: doc/BRIEF.md
# Signed Repeated-Addition Multiplier

This block multiplies two signed 8-bit operands without any shifter. It captures both operands when it sees `start` while idle. In the next cycle it turns the multiplier into its magnitude and keeps a sign flag. It then adds the multiplicand into an accumulator once for each unit of that magnitude. At the end it negates the accumulator if the sign flag says so. Because the loop runs once per unit of |b|, the run time grows with the multiplier's magnitude.

The result is the low 8 bits of the true product, and no overflow indication is produced. `done` pulses for one cycle when the product becomes valid. The result then stays on `result` until the next accepted `start`.

Top module: `repadd_mul`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and `result` is 0 until the first accepted start.
- R2: For any signed a and b, the completed `result` equals the low 8 bits of a*b. Both operands are two's complement.
- R3: When b is 0, the result is 0 and the block still completes, with the shortest latency.
- R4: `done` rises in the cycle after the (m+3)th rising edge that follows the edge at which `start` was accepted. Here m is the magnitude of b, taken as 128 for b = -128.
- R5: `done` is high for exactly one cycle per accepted start.
- R6: A `start` pulse while a multiplication is in progress is ignored. The result and the timing of the running operation are unchanged.
- R7: The operands are captured at the accepting edge. Changing `a` or `b` afterwards has no effect on the running operation.
- R8: After `done`, `result` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a multiplication; sampled only when idle |
| a | input | 8 | Signed multiplicand |
| b | input | 8 | Signed multiplier; its magnitude sets the loop count |
| result | output | 8 | Low 8 bits of the signed product |
| done | output | 1 | One-cycle pulse when `result` is valid |

## Verification
Each product is due exactly m+3 edges after the accepting edge, where m is the magnitude of b. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the accepting edge and compares that count with m+3, so a latency error fails even when the product is right. It reads `result` in the same cycle that `done` is seen. One cycle later it confirms that `done` has dropped and that `result` has not moved. A busy-start case injects a second request with new operands three cycles into a run, then checks that both the first product and its timing are unchanged.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_LOOP = 2'd2,
    ST_FIX  = 2'd3
  } rpm_state_e;
endpackage

// File: rtl/rpm_ctrl.sv
module rpm_ctrl
  import rpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cnt_zero,
  output logic       load,
  output logic       prep,
  output logic       step,
  output logic       fix
);
  rpm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_PREP;
      ST_PREP: state_d = ST_LOOP;
      ST_LOOP: if (cnt_zero) state_d = ST_FIX;
      ST_FIX:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign load = (state_q == ST_IDLE) && start;
  assign prep = (state_q == ST_PREP);
  assign step = (state_q == ST_LOOP) && !cnt_zero;
  assign fix  = (state_q == ST_FIX);

  // R6: a start seen mid-loop must not divert the sequence
  assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOP && start) |=> (state_q == ST_LOOP || state_q == ST_FIX));

  // R4: the fix-up state always hands over to idle
  assert_fix_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIX) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/rpm_operand.sv
module rpm_operand #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             prep,
  input  logic             step,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_q,
  output logic             sign_q,
  output logic             cnt_zero
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] cnt_q, cnt_d, a_d;
  logic             sign_d;
  logic             en;

  assign en = load | prep | step;

  always_comb begin
    a_d    = a_q;
    cnt_d  = cnt_q;
    sign_d = sign_q;
    if (load) begin
      a_d    = a_in;
      cnt_d  = b_in;
      sign_d = 1'b0;
    end else if (prep) begin
      if (cnt_q[MSB]) begin
        cnt_d  = WIDTH'(~cnt_q + 1'b1);
        sign_d = ~sign_q;
      end
    end else if (step) begin
      cnt_d = WIDTH'(cnt_q - 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      cnt_q  <= '0;
      sign_q <= 1'b0;
    end else if (en) begin
      a_q    <= a_d;
      cnt_q  <= cnt_d;
      sign_q <= sign_d;
    end
  end

  assign cnt_zero = (cnt_q == '0);

  // R4: each loop step removes exactly one unit of the multiplier
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == WIDTH'($past(cnt_q) - 1'b1)));

  // R7: captured multiplicand stays put while not loading
  assert_operand_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(a_q));
endmodule

// File: rtl/rpm_accum.sv
module rpm_accum #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             fix,
  input  logic             sign,
  input  logic [WIDTH-1:0] addend,
  output logic [WIDTH-1:0] acc_q
);
  logic [WIDTH-1:0] acc_d;
  logic             en;

  assign en = load | step | fix;

  always_comb begin
    acc_d = acc_q;
    if (load)                acc_d = '0;
    else if (step)           acc_d = WIDTH'(acc_q + addend);
    else if (fix && sign)    acc_d = WIDTH'(~acc_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end
endmodule

// File: rtl/repadd_mul.sv
module repadd_mul #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             load, prep, step, fix, cnt_zero, sign;
  logic [WIDTH-1:0] a_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rpm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .cnt_zero(cnt_zero),
    .load(load), .prep(prep), .step(step), .fix(fix)
  );

  rpm_operand #(.WIDTH(WIDTH)) u_operand (
    .clk(clk), .rst_n(rst_int_n), .load(load), .prep(prep), .step(step),
    .a_in(a), .b_in(b), .a_q(a_q), .sign_q(sign), .cnt_zero(cnt_zero)
  );

  rpm_accum #(.WIDTH(WIDTH)) u_accum (
    .clk(clk), .rst_n(rst_int_n), .load(load), .step(step), .fix(fix),
    .sign(sign), .addend(a_q), .acc_q(result)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) done_q <= 1'b0;
    else            done_q <= fix;
  end
  assign done = done_q;

  // R5: completion indication lasts a single cycle
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  // R8: a finished product stays visible until a new request
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !start) |=> $stable(result));
endmodule

// File: tb/repadd_mul_tb.sv
module repadd_mul_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] a, b;
  logic [7:0] result;
  logic       done;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  repadd_mul u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .result(result), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, got %0d cycles, expected < 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] expect_prod(logic [7:0] x, logic [7:0] y);
    int p;
    p = int'($signed(x)) * int'($signed(y));
    return p[7:0];
  endfunction

  function automatic int mag(logic [7:0] y);
    int v;
    v = int'($signed(y));
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // busy_at: cycle index at which a stray start is injected (0 = none)
  task automatic run(logic [7:0] xa, logic [7:0] xb, int busy_at);
    int m, n;
    logic [7:0] e, r;
    m = mag(xb);
    e = expect_prod(xa, xb);
    @(negedge clk);
    a = xa; b = xb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = ~xa; b = xb + 8'd1;          // R7: operand changes after capture
    n = 0;
    while (!done && n < m + 10) begin
      @(negedge clk);
      n = n + 1;
      if (busy_at != 0 && n == busy_at) begin
        start = 1'b1; a = 8'd100; b = 8'd2;   // R6 stray request
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    r = result;
    chk(r == e, (busy_at != 0) ? "R6 product" : "R2 R7 product", int'(r), int'(e));
    chk(n == m + 3, (m == 0) ? "R3 R4 latency" : "R4 latency", n, m + 3);
    @(negedge clk);
    chk(!done, "R5 done width", int'(done), 0);
    chk(result == r, "R8 hold", int'(result), int'(r));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    chk(!done && result == 8'd0, "R1 in reset", int'(result), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done, "R1 done after reset", int'(done), 0);
    chk(result == 8'd0, "R1 result after reset", int'(result), 0);

    // R3: zero multiplier
    run(8'd77, 8'd0, 0);
    run(8'h80, 8'd0, 0);

    // R2: every multiplicand against small multipliers of both signs
    for (int ia = 0; ia < 256; ia++) begin
      run(8'(ia), 8'd1, 0);
      run(8'(ia), 8'hFD, 0);
      run(8'(ia), 8'd4, 0);
    end

    // R2 R4: every multiplier against a few multiplicands
    for (int ib = 0; ib < 256; ib++) begin
      run(8'd3, 8'(ib), 0);
      run(8'hF9, 8'(ib), 0);
    end
    run(8'h80, 8'h80, 0);
    run(8'h7F, 8'h7F, 0);

    // R6: start while busy
    run(8'd5, 8'd9, 3);
    run(8'hF6, 8'hF8, 5);

    // R8: result held over idle cycles
    run(8'd12, 8'd6, 0);
    repeat (5) @(negedge clk);
    chk(result == 8'd72, "R8 long hold", int'(result), 72);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule